// File: doc/BRIEF.md
# Master-to-Frame Clock Ratio Detector

This block watches a master audio clock and a frame (left/right) clock that has already been brought into the master clock domain. It counts master cycles between consecutive rising frame edges and matches that count against the oversampling ratios a converter datapath can run at. Alongside the master count it counts pulses of a free-running reference tick over the same frame period, which gives the absolute frame rate. From that rate the block sorts the stream into one of three speed classes: single, double or quad.

A ratio is accepted only when the speed class allows it. The block locks after two identical accepted measurements in a row. While locked, it reports the ratio code, the speed class and the internal bit-clock settings that the serial input stage should use. A measured ratio that is illegal or that changes drops lock and raises an error flag. A frame clock that stops is caught by a timeout counted in reference ticks, and the whole detection then starts again from the beginning.

Top module: `clk_ratio_detect`

## Requirements
- R1: While reset is asserted and after its release until the first lock, `locked` and `ratio_err` are 0. Until then `ratio_code` is 15, `speed_mode` is 3, and `bclk_ratio` and `bclk_div` are 0.
- R2: The measured period is the number of master clock cycles from one rising `frame_clk` edge to the next. It maps to `ratio_code` as 64→0, 96→1, 128→2, 192→3, 256→4, 384→5, 512→6, 768→7, 1024→8, 1152→9. Any other count is illegal.
- R3: The speed class comes from the number of reference ticks counted in the same period. With at least SINGLE_MIN_TICKS ticks the class is single (`speed_mode` 0). With at least DOUBLE_MIN_TICKS ticks but fewer than SINGLE_MIN_TICKS it is double (1). Otherwise it is quad (2).
- R4: The legal codes are 4..9 for single, 2..7 for double and 0..4 for quad. An illegal period clears `locked` and sets `ratio_err` at the edge that samples the closing frame rise.
- R5: The first rising frame edge after reset or after a timeout only starts a measurement. `locked` rises at the rise that completes a second legal measurement equal in code and class to the one before it, which is the third rise.
- R6: While locked, `bclk_ratio` is 48 for codes 1, 3, 5 and 7, and 72 for code 9. For the other codes it is 64 when `fmt_wide` is 1 and 32 when it is 0. `bclk_div` equals the master ratio divided by `bclk_ratio`.
- R7: A legal measurement that differs from the previous one while locked clears `locked` and sets `ratio_err`. The error stays set until a confirmation locks again, and that confirmation clears it.
- R8: When TIMEOUT_TICKS reference ticks pass without a rising frame edge, `locked` and `ratio_err` both go to 0 and detection restarts as in R5. Before that count is reached, lock is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master audio clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_clk | input | 1 | Frame clock, already synchronous to clk |
| ref_tick | input | 1 | One-cycle reference pulse at a fixed absolute rate |
| fmt_wide | input | 1 | Data format selects 64 (1) or 32 (0) bit clocks per frame where the ratio permits both |
| ratio_code | output | 4 | Code of the confirmed master-to-frame ratio, 15 when none |
| speed_mode | output | 2 | 0 single, 1 double, 2 quad, 3 none |
| locked | output | 1 | Ratio and speed confirmed |
| ratio_err | output | 1 | Unsupported or changed ratio seen |
| bclk_ratio | output | 7 | Internal bit clocks per frame |
| bclk_div | output | 6 | Master cycles per internal bit clock |

## Verification
Every result of this block changes at the clock edge that first samples `frame_clk` high after it was low. A rise driven by the bench therefore becomes visible after the next edge. The bench waits for its own frame rise and then samples at the following falling clock edge, where the effect of that rise has already registered. Lock checks count rises from the start of a run: none at the second rise, locked at the third. Timeout checks sample at cycle counts well below and well above the tick window.

// File: rtl/clk_ratio_pkg.sv
package clk_ratio_pkg;

    typedef enum logic [1:0] {
        SPD_SINGLE = 2'd0,
        SPD_DOUBLE = 2'd1,
        SPD_QUAD   = 2'd2,
        SPD_NONE   = 2'd3
    } speed_e;

    localparam int unsigned NUM_RATIOS = 10;
    localparam logic [3:0]  CODE_NONE  = 4'd15;

    function automatic int unsigned ratio_of(input int unsigned code);
        case (code)
            0: ratio_of = 64;
            1: ratio_of = 96;
            2: ratio_of = 128;
            3: ratio_of = 192;
            4: ratio_of = 256;
            5: ratio_of = 384;
            6: ratio_of = 512;
            7: ratio_of = 768;
            8: ratio_of = 1024;
            default: ratio_of = 1152;
        endcase
    endfunction

endpackage

// File: rtl/crd_period_counter.sv
module crd_period_counter #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         restart,
    output logic [W-1:0] sample
);
    logic [W-1:0] count_d, count_q;

    always_comb begin
        if (count_q == '1) sample = count_q;
        else               sample = count_q + W'(inc);
        count_d = restart ? '0 : sample;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end
endmodule

// File: rtl/crd_speed_classify.sv
module crd_speed_classify
    import clk_ratio_pkg::*;
#(
    parameter int TW               = 13,
    parameter int SINGLE_MIN_TICKS = 128,
    parameter int DOUBLE_MIN_TICKS = 64
) (
    input  logic [TW-1:0] ticks,
    output speed_e        speed
);
    always_comb begin
        if (ticks >= TW'(SINGLE_MIN_TICKS))      speed = SPD_SINGLE;
        else if (ticks >= TW'(DOUBLE_MIN_TICKS)) speed = SPD_DOUBLE;
        else                                     speed = SPD_QUAD;
    end
endmodule

// File: rtl/crd_ratio_classify.sv
module crd_ratio_classify
    import clk_ratio_pkg::*;
#(
    parameter int CW = 12
) (
    input  logic [CW-1:0] count,
    input  speed_e        speed,
    input  logic          fmt_wide,
    output logic [3:0]    code,
    output logic          legal,
    output logic [6:0]    bclk,
    output logic [5:0]    div
);
    always_comb begin
        code = CODE_NONE;
        for (int i = 0; i < NUM_RATIOS; i++) begin
            if (count == CW'(ratio_of(i))) code = 4'(i);
        end

        case (speed)
            SPD_SINGLE: legal = (code >= 4'd4) && (code <= 4'd9);
            SPD_DOUBLE: legal = (code >= 4'd2) && (code <= 4'd7);
            SPD_QUAD:   legal = (code <= 4'd4);
            default:    legal = 1'b0;
        endcase

        case (code)
            4'd1, 4'd3, 4'd5, 4'd7: bclk = 7'd48;
            4'd9:                   bclk = 7'd72;
            CODE_NONE:              bclk = 7'd0;
            default:                bclk = fmt_wide ? 7'd64 : 7'd32;
        endcase

        case (code)
            4'd0: div = fmt_wide ? 6'd1  : 6'd2;
            4'd1: div = 6'd2;
            4'd2: div = fmt_wide ? 6'd2  : 6'd4;
            4'd3: div = 6'd4;
            4'd4: div = fmt_wide ? 6'd4  : 6'd8;
            4'd5: div = 6'd8;
            4'd6: div = fmt_wide ? 6'd8  : 6'd16;
            4'd7: div = 6'd16;
            4'd8: div = fmt_wide ? 6'd16 : 6'd32;
            4'd9: div = 6'd16;
            default: div = 6'd0;
        endcase
    end
endmodule

// File: rtl/clk_ratio_detect.sv
module clk_ratio_detect
    import clk_ratio_pkg::*;
#(
    parameter int MAX_RATIO        = 1152,
    parameter int SINGLE_MIN_TICKS = 128,
    parameter int DOUBLE_MIN_TICKS = 64,
    parameter int TIMEOUT_TICKS    = 4096
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_clk,
    input  logic       ref_tick,
    input  logic       fmt_wide,
    output logic [3:0] ratio_code,
    output logic [1:0] speed_mode,
    output logic       locked,
    output logic       ratio_err,
    output logic [6:0] bclk_ratio,
    output logic [5:0] bclk_div
);
    localparam int CW = $clog2(MAX_RATIO * 2);
    localparam int TW = $clog2(TIMEOUT_TICKS + 1) + 1;

    typedef struct packed {
        logic       frame;
        logic       seen;
        logic       prev_ok;
        logic [3:0] prev_code;
        speed_e     prev_spd;
        logic       locked;
        logic       err;
        logic [3:0] code;
        speed_e     spd;
        logic [6:0] bclk;
        logic [5:0] div;
    } state_t;

    state_t s_d, s_q;

    logic          rise;
    logic          timeout;
    logic [CW-1:0] mclk_cnt;
    logic [TW-1:0] tick_cnt;
    speed_e        meas_spd;
    logic [3:0]    meas_code;
    logic          meas_legal;
    logic [6:0]    meas_bclk;
    logic [5:0]    meas_div;

    assign rise = frame_clk & ~s_q.frame;

    crd_period_counter #(.W(CW)) u_mclk_cnt (
        .clk(clk), .rst_n(rst_n), .inc(1'b1), .restart(rise), .sample(mclk_cnt)
    );

    crd_period_counter #(.W(TW)) u_tick_cnt (
        .clk(clk), .rst_n(rst_n), .inc(ref_tick), .restart(rise), .sample(tick_cnt)
    );

    crd_speed_classify #(
        .TW(TW), .SINGLE_MIN_TICKS(SINGLE_MIN_TICKS), .DOUBLE_MIN_TICKS(DOUBLE_MIN_TICKS)
    ) u_speed (
        .ticks(tick_cnt), .speed(meas_spd)
    );

    crd_ratio_classify #(.CW(CW)) u_ratio (
        .count(mclk_cnt), .speed(meas_spd), .fmt_wide(fmt_wide),
        .code(meas_code), .legal(meas_legal), .bclk(meas_bclk), .div(meas_div)
    );

    assign timeout = (tick_cnt >= TW'(TIMEOUT_TICKS));

    always_comb begin
        s_d       = s_q;
        s_d.frame = frame_clk;
        if (rise) begin
            s_d.seen = 1'b1;
            if (s_q.seen) begin
                if (!meas_legal) begin
                    s_d.locked  = 1'b0;
                    s_d.err     = 1'b1;
                    s_d.prev_ok = 1'b0;
                end else if (s_q.prev_ok && s_q.prev_code == meas_code
                             && s_q.prev_spd == meas_spd) begin
                    s_d.locked = 1'b1;
                    s_d.err    = 1'b0;
                    s_d.code   = meas_code;
                    s_d.spd    = meas_spd;
                    s_d.bclk   = meas_bclk;
                    s_d.div    = meas_div;
                end else begin
                    s_d.locked    = 1'b0;
                    s_d.err       = s_q.err | s_q.locked;
                    s_d.prev_ok   = 1'b1;
                    s_d.prev_code = meas_code;
                    s_d.prev_spd  = meas_spd;
                end
            end
        end else if (timeout) begin
            s_d.seen    = 1'b0;
            s_d.prev_ok = 1'b0;
            s_d.locked  = 1'b0;
            s_d.err     = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q           <= '0;
            s_q.prev_code <= CODE_NONE;
            s_q.prev_spd  <= SPD_NONE;
            s_q.code      <= CODE_NONE;
            s_q.spd       <= SPD_NONE;
        end else begin
            s_q <= s_d;
        end
    end

    assign ratio_code = s_q.code;
    assign speed_mode = s_q.spd;
    assign locked     = s_q.locked;
    assign ratio_err  = s_q.err;
    assign bclk_ratio = s_q.bclk;
    assign bclk_div   = s_q.div;
endmodule

// File: rtl/crd_checker.sv
module crd_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       frame_clk,
    input logic [3:0] ratio_code,
    input logic [1:0] speed_mode,
    input logic       locked,
    input logic       ratio_err,
    input logic [6:0] bclk_ratio,
    input logic [5:0] bclk_div
);
    // R4
    lock_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(locked && ratio_err));

    // R5
    lock_on_frame_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> ($past(frame_clk) && !$past(frame_clk, 2)));

    // R2
    locked_code_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> (ratio_code <= 4'd9 && speed_mode != 2'd3));

    // R6
    locked_bclk_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> ((bclk_ratio == 7'd32 || bclk_ratio == 7'd48 ||
                     bclk_ratio == 7'd64 || bclk_ratio == 7'd72) && bclk_div != 6'd0));

    // R4
    single_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && speed_mode == 2'd0) |-> ratio_code >= 4'd4);

    // R4
    quad_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && speed_mode == 2'd2) |-> ratio_code <= 4'd4);
endmodule

bind clk_ratio_detect crd_checker u_chk (
    .clk(clk), .rst_n(rst_n), .frame_clk(frame_clk),
    .ratio_code(ratio_code), .speed_mode(speed_mode), .locked(locked),
    .ratio_err(ratio_err), .bclk_ratio(bclk_ratio), .bclk_div(bclk_div)
);

// File: tb/clk_ratio_detect_bench.sv
`timescale 1ns/1ps
module clk_ratio_detect_bench;
    typedef struct packed {
        int         n;
        int         k;
        logic       fmt;
        logic       legal;
        logic [3:0] code;
        logic [1:0] spd;
        logic [6:0] bclk;
        logic [5:0] div;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{256,  8,  1'b0, 1'b1, 4'd4, 2'd0, 7'd32, 6'd8},
        '{256,  24, 1'b1, 1'b1, 4'd4, 2'd1, 7'd64, 6'd4},
        '{256,  64, 1'b0, 1'b1, 4'd4, 2'd2, 7'd32, 6'd8},
        '{384,  16, 1'b0, 1'b1, 4'd5, 2'd0, 7'd48, 6'd8},
        '{1152, 48, 1'b0, 1'b1, 4'd9, 2'd0, 7'd72, 6'd16},
        '{1024, 40, 1'b1, 1'b1, 4'd8, 2'd0, 7'd64, 6'd16},
        '{128,  12, 1'b0, 1'b1, 4'd2, 2'd1, 7'd32, 6'd4},
        '{96,   16, 1'b0, 1'b1, 4'd1, 2'd2, 7'd48, 6'd2},
        '{64,   16, 1'b1, 1'b1, 4'd0, 2'd2, 7'd64, 6'd1},
        '{768,  64, 1'b0, 1'b1, 4'd7, 2'd1, 7'd48, 6'd16},
        '{1024, 85, 1'b0, 1'b0, 4'd0, 2'd0, 7'd0,  6'd0},
        '{64,   2,  1'b0, 1'b0, 4'd0, 2'd0, 7'd0,  6'd0},
        '{200,  8,  1'b0, 1'b0, 4'd0, 2'd0, 7'd0,  6'd0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_clk = 1'b0;
    logic       ref_tick = 1'b0;
    logic       fmt_wide = 1'b0;
    logic [3:0] ratio_code;
    logic [1:0] speed_mode;
    logic       locked;
    logic       ratio_err;
    logic [6:0] bclk_ratio;
    logic [5:0] bclk_div;

    logic frame_en = 1'b0;
    int   half = 128;
    int   k = 8;
    int   fcnt = 0;
    int   tk = 0;
    int   n_run = 0;
    int   n_fail = 0;

    always #2 clk = ~clk;

    clk_ratio_detect #(
        .SINGLE_MIN_TICKS(16), .DOUBLE_MIN_TICKS(8), .TIMEOUT_TICKS(64)
    ) u_clk_ratio_detect (
        .clk(clk), .rst_n(rst_n), .frame_clk(frame_clk), .ref_tick(ref_tick),
        .fmt_wide(fmt_wide), .ratio_code(ratio_code), .speed_mode(speed_mode),
        .locked(locked), .ratio_err(ratio_err), .bclk_ratio(bclk_ratio),
        .bclk_div(bclk_div)
    );

    always @(negedge clk) begin
        if (!frame_en) begin
            frame_clk <= 1'b0;
            fcnt      <= 0;
        end else if (fcnt >= half - 1) begin
            frame_clk <= ~frame_clk;
            fcnt      <= 0;
        end else begin
            fcnt <= fcnt + 1;
        end
    end

    always @(negedge clk) begin
        if (tk >= k - 1) begin
            ref_tick <= 1'b1;
            tk       <= 0;
        end else begin
            ref_tick <= 1'b0;
            tk       <= tk + 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic after_rise();
        @(posedge frame_clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (5) @(negedge clk);
        chk("R1 locked", locked, 0);
        chk("R1 err", ratio_err, 0);
        chk("R1 code", ratio_code, 15);
        chk("R1 speed", speed_mode, 3);
        chk("R1 bclk", bclk_ratio, 0);
        chk("R1 div", bclk_div, 0);
        rst_n    = 1'b1;
        frame_en = 1'b1;

        // R5 first lock at third rise
        after_rise();
        chk("R1 locked after first rise", locked, 0);
        after_rise();
        chk("R5 not locked at second rise", locked, 0);
        chk("R5 no error at second rise", ratio_err, 0);
        after_rise();
        chk("R5 locked at third rise", locked, 1);
        chk("R2 code 256", ratio_code, 4);

        // R8 timeout
        @(negedge clk);
        frame_en = 1'b0;
        repeat (300) @(negedge clk);
        chk("R8 lock held inside window", locked, 1);
        repeat (400) @(negedge clk);
        chk("R8 lock cleared by timeout", locked, 0);
        chk("R8 err cleared by timeout", ratio_err, 0);
        frame_en = 1'b1;
        after_rise();
        after_rise();
        chk("R8 restart not locked at second rise", locked, 0);
        after_rise();
        chk("R8 restart locked at third rise", locked, 1);

        // R7 change while locked: 256 -> 512
        @(posedge frame_clk);
        @(posedge clk);
        half = 256;
        k    = 16;
        after_rise();
        chk("R7 change drops lock", locked, 0);
        chk("R7 change raises err", ratio_err, 1);
        after_rise();
        chk("R7 relock on confirm", locked, 1);
        chk("R7 err cleared on confirm", ratio_err, 0);
        chk("R7 new code 512", ratio_code, 6);

        // table walk: R2 R3 R4 R6
        for (int i = 0; i < NV; i++) begin
            @(posedge clk);
            half     = VEC[i].n / 2;
            k        = VEC[i].k;
            fmt_wide = VEC[i].fmt;
            repeat (4) after_rise();
            if (VEC[i].legal) begin
                chk("R5 locked row", locked, 1);
                chk("R4 no err row", ratio_err, 0);
                chk("R2 code row", ratio_code, VEC[i].code);
                chk("R3 speed row", speed_mode, VEC[i].spd);
                chk("R6 bclk row", bclk_ratio, VEC[i].bclk);
                chk("R6 div row", bclk_div, VEC[i].div);
            end else begin
                chk("R4 illegal not locked", locked, 0);
                chk("R4 illegal err", ratio_err, 1);
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule